// File: doc/BRIEF.md
# Transmit Descriptor Completion Reporter

This block sits behind a transmit descriptor fetch engine. The engine hands over legacy descriptors one at a time, each as a command byte and its ring index. The block groups consecutive descriptors into packets, where the descriptor with its end-of-packet bit set closes a packet. When the packet datapath signals through a one-cycle `pkt_buffered` pulse that the oldest outstanding packet now sits in the output FIFO, the block tells software that the packet is finished. It does this by issuing write requests toward a memory-write port.

Two reporting styles are available, selected by `tail_wb_en`. In status mode, every descriptor whose report-status bit is set produces a status write-back request that marks that descriptor done. Descriptors without the bit produce no request. In tail write-back mode, no per-descriptor status write is issued at all. Instead, each packet that contains at least one report-status descriptor produces one head-pointer write carrying the ring index that follows the packet's last descriptor. That index wraps to zero at the programmable ring size. Done flags therefore imply that every earlier packet has also been buffered.

Both streams use valid/ready handshakes. A descriptor transfers on a cycle where `desc_valid` and `desc_ready` are both high. `desc_ready` drops when the internal completion queue of eight descriptors is full, and it rises again as queued descriptors are retired. A request transfers on a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, the pending request holds and retirement stops.

Top module: `txc_report`

## Requirements
- R1: Command byte fields used: bit 0 is end-of-packet, bit 3 is report-status, bit 5 is extension. Bits 1, 2, 4, 6 and 7 have no effect on any request.
- R2: With `tail_wb_en` low, each descriptor with report-status set produces exactly one request with `req_kind`=0 and `req_idx` equal to its index. A descriptor without report-status produces none.
- R3: No request for a packet's descriptors is issued before a `pkt_buffered` pulse has been received for that packet. Pulses are matched to packets oldest first.
- R4: With `tail_wb_en` high, no request with `req_kind`=0 is issued. Each packet containing a report-status descriptor produces exactly one request with `req_kind`=1, issued after its last descriptor. Packets without report-status produce none.
- R5: The head value is the end-of-packet index plus one, or 0 when that index equals `ring_size`-1.
- R6: Requests leave in the order the descriptors were accepted.
- R7: An accepted descriptor with the extension bit set makes `ext_err` go high and stay high until reset. That descriptor is otherwise reported like any other.
- R8: `desc_ready` is low while eight descriptors are held unretired, and it returns high once one is retired.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_kind` and `req_idx` hold their values on the next cycle.
- R10: After reset, `req_valid`=0, `desc_ready`=1 and `ext_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tail_wb_en | input | 1 | 1 selects head-pointer reporting, 0 selects per-descriptor status |
| ring_size | input | IDX_W | Number of descriptors in the ring (at least 2) |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be accepted |
| desc_cmd | input | 8 | Descriptor command byte |
| desc_idx | input | IDX_W | Ring index of the descriptor |
| pkt_buffered | input | 1 | One-cycle pulse: the oldest open packet is in the output FIFO |
| req_valid | output | 1 | Write request pending |
| req_ready | input | 1 | Memory-write port accepts the request |
| req_kind | output | 1 | 0 = status write-back, 1 = head-pointer write |
| req_idx | output | IDX_W | Descriptor index (status) or new head value (head) |
| ext_err | output | 1 | Sticky: an extension-bit descriptor was seen |

## Verification
The embedded assertions check on every cycle that a stalled request holds steady, that the error flag never clears, that tail mode never lets a status request through, that head values stay inside the ring, and that the queue and pulse counter never exceed their bounds. Only the bench's scenarios can show that exactly the right set of requests appears, in acceptance order, for random packet shapes and random command bits. The same holds for head values wrapping at a small ring size, for nothing being reported before the matching pulse, and for acceptance stalling on a full queue and resuming after retirement.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int CMD_EOP = 0;
  localparam int CMD_RS  = 3;
  localparam int CMD_EXT = 5;
  localparam logic KIND_STATUS = 1'b0;
  localparam logic KIND_HEAD   = 1'b1;
endpackage

// File: rtl/txc_fifo.sv
module txc_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3
endmodule

// File: rtl/txc_drain.sv
module txc_drain #(
  parameter int IDX_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tail_wb_en,
  input  logic [IDX_W-1:0] ring_size,
  input  logic             pkt_buffered,
  input  logic             q_empty,
  input  logic             e_eop,
  input  logic             e_rs,
  input  logic [IDX_W-1:0] e_idx,
  output logic             q_pop,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_kind,
  output logic [IDX_W-1:0] req_idx
);
  import txc_pkg::*;
  localparam int CRW = $clog2(DEPTH + 1) + 1;

  logic [CRW-1:0]   credit;
  logic             rs_seen;
  logic             emit;
  logic             kind_n;
  logic [IDX_W-1:0] idx_n;
  logic [IDX_W-1:0] head_n;

  assign head_n = (e_idx == ring_size - 1'b1) ? '0 : e_idx + 1'b1;
  assign q_pop  = !q_empty && (credit != '0) && (!req_valid || req_ready);

  always_comb begin
    if (tail_wb_en) begin
      emit   = e_eop && (rs_seen || e_rs);
      kind_n = KIND_HEAD;
      idx_n  = head_n;
    end else begin
      emit   = e_rs;
      kind_n = KIND_STATUS;
      idx_n  = e_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit    <= '0;
      rs_seen   <= 1'b0;
      req_valid <= 1'b0;
      req_kind  <= KIND_STATUS;
      req_idx   <= '0;
    end else begin
      credit <= credit + CRW'(pkt_buffered) - CRW'(q_pop && e_eop);
      if (q_pop) rs_seen <= e_eop ? 1'b0 : (rs_seen || e_rs);
      if (q_pop && emit) begin
        req_valid <= 1'b1;
        req_kind  <= kind_n;
        req_idx   <= idx_n;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) && $stable(req_idx)); // R9
  AST_TAIL_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop && tail_wb_en |=> !req_valid || req_kind == KIND_HEAD); // R4
  AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == KIND_HEAD |-> req_idx < ring_size); // R5
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CRW'(DEPTH)); // R3
endmodule

// File: rtl/txc_report.sv
module txc_report #(
  parameter int IDX_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tail_wb_en,
  input  logic [IDX_W-1:0] ring_size,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [7:0]       desc_cmd,
  input  logic [IDX_W-1:0] desc_idx,
  input  logic             pkt_buffered,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_kind,
  output logic [IDX_W-1:0] req_idx,
  output logic             ext_err
);
  import txc_pkg::*;
  localparam int EW = IDX_W + 2;

  logic          q_full, q_empty, q_pop, q_push;
  logic [EW-1:0] q_wdata, q_rdata;

  assign desc_ready = !q_full;
  assign q_push     = desc_valid && desc_ready;
  assign q_wdata    = {desc_cmd[CMD_RS], desc_cmd[CMD_EOP], desc_idx};

  txc_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(q_wdata),
    .pop(q_pop), .rdata(q_rdata), .full(q_full), .empty(q_empty)
  );

  txc_drain #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_drain (
    .clk(clk), .rst_n(rst_n), .tail_wb_en(tail_wb_en), .ring_size(ring_size),
    .pkt_buffered(pkt_buffered), .q_empty(q_empty),
    .e_eop(q_rdata[IDX_W]), .e_rs(q_rdata[IDX_W+1]), .e_idx(q_rdata[IDX_W-1:0]),
    .q_pop(q_pop), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_idx(req_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_err <= 1'b0;
    else if (q_push && desc_cmd[CMD_EXT]) ext_err <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_err |=> ext_err); // R7
  AST_EXT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    q_push && desc_cmd[CMD_EXT] |=> ext_err); // R7
endmodule

// File: tb/sim_txc_report.sv
module sim_txc_report;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tail_wb_en = 1'b0;
  logic [IDX_W-1:0] ring_size = 8'd13;
  logic             desc_valid = 1'b0;
  logic             desc_ready;
  logic [7:0]       desc_cmd = '0;
  logic [IDX_W-1:0] desc_idx = '0;
  logic             pkt_buffered = 1'b0;
  logic             req_valid;
  logic             req_ready = 1'b0;
  logic             req_kind;
  logic [IDX_W-1:0] req_idx;
  logic             ext_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit rdy_rand = 1;
  int cur_idx = 0;
  logic             exp_kind[$];
  logic [IDX_W-1:0] exp_idx[$];

  always #2 clk = ~clk;

  txc_report #(.IDX_W(IDX_W), .DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tail_wb_en(tail_wb_en), .ring_size(ring_size),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_cmd(desc_cmd),
    .desc_idx(desc_idx), .pkt_buffered(pkt_buffered), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_idx(req_idx), .ext_err(ext_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] next_head(input int idx, input int ring);
    return (idx == ring - 1) ? '0 : IDX_W'(idx + 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // request monitor: choose ready, then record any handshake at the coming edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
    req_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b0;
    if (rst_n && req_valid && req_ready) begin
      if (exp_kind.size() == 0) begin
        check("R6 unexpected request", {23'd0, req_kind, req_idx}, 32'hFFFF);
      end else begin
        // R2 R4 R5 R6: kind and index in acceptance order
        check("R6 req_kind", 32'(req_kind), 32'(exp_kind[0]));
        check("R5 req_idx", 32'(req_idx), 32'(exp_idx[0]));
        void'(exp_kind.pop_front());
        void'(exp_idx.pop_front());
      end
    end
  end

  task automatic send_desc(input logic [7:0] cmd);
    desc_valid = 1'b1;
    desc_cmd   = cmd;
    desc_idx   = IDX_W'(cur_idx);
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    cur_idx = (cur_idx + 1) % int'(ring_size);
  endtask

  task automatic pulse();
    pkt_buffered = 1'b1;
    @(negedge clk);
    pkt_buffered = 1'b0;
  endtask

  // R1: random ignored bits 1,2,4,6,7; extension kept clear here
  task automatic send_packet(input int n, input bit force_rs);
    bit any_rs = 0;
    int last = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] cmd;
      bit rs;
      cmd = 8'($urandom) & 8'b1101_0110;
      rs  = force_rs || ($urandom % 3 == 0);
      cmd[3] = rs;
      cmd[0] = (i == n - 1);
      if (rs) any_rs = 1;
      if (rs && !tail_wb_en) begin
        exp_kind.push_back(1'b0);
        exp_idx.push_back(IDX_W'(cur_idx));
      end
      last = cur_idx;
      send_desc(cmd);
    end
    if (tail_wb_en && any_rs) begin
      exp_kind.push_back(1'b1);
      exp_idx.push_back(next_head(last, int'(ring_size)));
    end
  endtask

  task automatic drain_wait();
    for (int k = 0; k < 2000 && exp_kind.size() != 0; k++) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R6 all expected requests seen", 32'(exp_kind.size()), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 req_valid", 32'(req_valid), 32'd0);
    check("R10 desc_ready", 32'(desc_ready), 32'd1);
    check("R10 ext_err", 32'(ext_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: status mode, random packets
    tail_wb_en = 1'b0; ring_size = 8'd13; cur_idx = 0;
    for (int p = 0; p < 40; p++) begin
      send_packet(1 + int'($urandom % 3), 1'b0);
      pulse();
    end
    drain_wait();

    // R4 R5: tail mode, small ring forces wraps
    tail_wb_en = 1'b1; ring_size = 8'd5; cur_idx = 0;
    for (int p = 0; p < 40; p++) begin
      send_packet(1 + int'($urandom % 3), 1'b0);
      pulse();
    end
    drain_wait();
    // R5 directed: end-of-packet at index ring_size-1 gives head 0
    cur_idx = 3;
    send_packet(2, 1'b1);
    pulse();
    drain_wait();
    check("R5 wrap consumed index", 32'(cur_idx), 32'd0);

    // R3 R8: fill the queue with no pulse
    tail_wb_en = 1'b0; ring_size = 8'd13; cur_idx = 0;
    for (int p = 0; p < 8; p++) send_packet(1, 1'b1);
    repeat (5) @(negedge clk);
    check("R8 desc_ready low when full", 32'(desc_ready), 32'd0);
    check("R3 nothing before pulse", 32'(req_valid), 32'd0);
    check("R3 nothing consumed", 32'(exp_kind.size()), 32'd8);
    pulse();
    repeat (3) @(negedge clk);
    check("R8 desc_ready back", 32'(desc_ready), 32'd1);
    for (int p = 0; p < 7; p++) pulse();
    drain_wait();

    // R9: stall output and verify hold
    rdy_rand = 0;
    send_packet(1, 1'b1);
    pulse();
    repeat (3) @(negedge clk);
    check("R9 valid held", 32'(req_valid), 32'd1);
    check("R9 idx held", 32'(req_idx), 32'(exp_idx[0]));
    repeat (3) @(negedge clk);
    check("R9 still held", 32'(req_valid), 32'd1);
    rdy_rand = 1;
    drain_wait();

    // R7: extension bit sets sticky flag, descriptor still reported
    check("R7 ext_err before", 32'(ext_err), 32'd0);
    exp_kind.push_back(1'b0);
    exp_idx.push_back(IDX_W'(cur_idx));
    send_desc(8'b0010_1001);
    pulse();
    drain_wait();
    check("R7 ext_err set", 32'(ext_err), 32'd1);
    send_packet(2, 1'b0);
    pulse();
    drain_wait();
    check("R7 ext_err sticky", 32'(ext_err), 32'd1);

    finish_run();
  end
endmodule